// File: doc/BRIEF.md
# DMA Burst Address and Size Engine

This block walks a single loaded DMA command, turning it into a series of burst requests toward memory. A command carries a source address, a destination address, a byte count stored minus one, a per-side access width, a per-side address-increment enable, a burst length in bytes stored minus one, and an enable for pacing by a peripheral request line. Once a command is started, the engine presents one burst at a time on a request/acknowledge pair. Each request carries the current read address, the current write address, the burst length and the two access widths.

Each accepted burst lowers a live remaining-size count and advances each address whose increment is enabled. A side with increment disabled keeps its address fixed, which suits a peripheral FIFO. The burst length shrinks by one bus word when either end address is misaligned to the bus. The final burst is cut down to whatever bytes are left. When the last burst is accepted, the engine drops back to idle and pulses `done`. The remaining count then reads all ones, which means nothing is left to move.

Top module: `dma_burst_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `bus_req` and `done` are low and `remain_m1` is all ones.
- R2: A `start` pulse while idle loads the command, so that one cycle later `busy` is high and `remain_m1` equals `size_m1`. A `start` while busy has no effect on the addresses or the count.
- R3: Every burst except the final one has a length of `burst_m1`+1 bytes, shown on `req_len_m1` as length minus one.
- R4: With a bus of 8 bytes, the burst cap is reduced by 8 bytes if bits [2:0] of either the loaded source or the destination address are nonzero, provided `burst_m1` is at least 8. Below 8 the cap stays unchanged.
- R5: The final burst carries exactly the remaining byte count, which may be shorter than the cap.
- R6: Each cycle in which `bus_req` and `bus_ack` are both high lowers `remain_m1` by the burst length. Without an acknowledge, `remain_m1` and both addresses hold.
- R7: On each accepted burst, a side whose increment enable is 1 advances its address by the burst length. A side whose enable is 0 keeps its loaded address.
- R8: When `dreq_en` was set at load, `bus_req` stays low while `dreq` is low, and it rises while `dreq` is high.
- R9: One cycle after the final burst is accepted, `done` is high for exactly one cycle, `busy` is low and `remain_m1` is all ones.
- R10: `req_rd_width` and `req_wr_width` show the widths captured at load, coded 0..3 for 1, 2, 4 and 8 bytes, and they ignore later changes on the width inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Load the command when idle |
| src_addr | input | 32 | Source start address |
| dst_addr | input | 32 | Destination start address |
| size_m1 | input | 24 | Byte count minus one |
| rd_width | input | 3 | Read access width code (log2 bytes) |
| wr_width | input | 3 | Write access width code (log2 bytes) |
| rd_inc | input | 1 | Advance read address per burst |
| wr_inc | input | 1 | Advance write address per burst |
| burst_m1 | input | 8 | Burst length in bytes minus one |
| dreq_en | input | 1 | Pace bursts by the peripheral request |
| dreq | input | 1 | Peripheral request |
| bus_ack | input | 1 | Memory side accepts the current burst |
| busy | output | 1 | Command in progress |
| bus_req | output | 1 | Burst request valid |
| req_rd_addr | output | 32 | Read address of the current burst |
| req_wr_addr | output | 32 | Write address of the current burst |
| req_len_m1 | output | 8 | Current burst length minus one |
| req_rd_width | output | 3 | Read width code held for the command |
| req_wr_width | output | 3 | Write width code held for the command |
| remain_m1 | output | 24 | Remaining bytes minus one, all ones when none |
| done | output | 1 | One-cycle pulse when the command finishes |

## Verification
The splitting logic is tried on several commands:
- An aligned command whose size leaves a short tail.
- One whose size is an exact multiple of the cap, so the last burst is full-length.
- A single-byte command.
- A 256-byte cap.
- Misaligned source and destination addresses with caps above and below one bus word. These separate a correct alignment shrink from a missing or unconditional one.

For every burst the bench checks the request length, both addresses and the count that follows. This distinguishes a wrong step size, a wrong tail length, and an off-by-one in the all-ones end marker. Directed runs cover:
- A stalled acknowledge.
- A start while busy.
- Width capture.
- Request pacing held off and then released.
- A fixed read address.

// File: rtl/dma_burst_engine.sv
module dma_burst_engine #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 24,
  parameter int BURST_W  = 8,
  parameter int BUS_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [ADDR_W-1:0]  dst_addr,
  input  logic [SIZE_W-1:0]  size_m1,
  input  logic [2:0]         rd_width,
  input  logic [2:0]         wr_width,
  input  logic               rd_inc,
  input  logic               wr_inc,
  input  logic [BURST_W-1:0] burst_m1,
  input  logic               dreq_en,
  input  logic               dreq,
  input  logic               bus_ack,
  output logic               busy,
  output logic               bus_req,
  output logic [ADDR_W-1:0]  req_rd_addr,
  output logic [ADDR_W-1:0]  req_wr_addr,
  output logic [BURST_W-1:0] req_len_m1,
  output logic [2:0]         req_rd_width,
  output logic [2:0]         req_wr_width,
  output logic [SIZE_W-1:0]  remain_m1,
  output logic               done
);
  localparam int BUS_BYTES = 1 << BUS_LOG2;
  localparam logic [BURST_W-1:0] BUS_M = BURST_W'(BUS_BYTES);

  logic               busy_q, done_q, rd_inc_q, wr_inc_q, gate_q;
  logic [ADDR_W-1:0]  rd_addr_q, wr_addr_q;
  logic [SIZE_W-1:0]  remain_q;
  logic [BURST_W-1:0] cap_q;
  logic [2:0]         rdw_q, wrw_q;

  logic               misaligned, shrink, last, xfer;
  logic [BURST_W-1:0] cap_load, len_m1;
  logic [ADDR_W-1:0]  step;

  assign misaligned = (|src_addr[BUS_LOG2-1:0]) || (|dst_addr[BUS_LOG2-1:0]);
  assign shrink     = misaligned && (burst_m1 >= BUS_M);
  assign cap_load   = shrink ? burst_m1 - BUS_M : burst_m1;

  assign last    = remain_q <= SIZE_W'(cap_q);
  assign len_m1  = last ? remain_q[BURST_W-1:0] : cap_q;
  assign step    = ADDR_W'(len_m1) + ADDR_W'(1);
  assign bus_req = busy_q && (!gate_q || dreq);
  assign xfer    = bus_req && bus_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_inc_q  <= 1'b0;
      wr_inc_q  <= 1'b0;
      gate_q    <= 1'b0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      remain_q  <= '1;
      cap_q     <= '0;
      rdw_q     <= '0;
      wrw_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        busy_q    <= 1'b1;
        rd_addr_q <= src_addr;
        wr_addr_q <= dst_addr;
        remain_q  <= size_m1;
        cap_q     <= cap_load;
        rd_inc_q  <= rd_inc;
        wr_inc_q  <= wr_inc;
        gate_q    <= dreq_en;
        rdw_q     <= rd_width;
        wrw_q     <= wr_width;
      end else if (xfer) begin
        remain_q <= remain_q - SIZE_W'(len_m1) - SIZE_W'(1);
        if (rd_inc_q) rd_addr_q <= rd_addr_q + step;
        if (wr_inc_q) wr_addr_q <= wr_addr_q + step;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign req_rd_addr  = rd_addr_q;
  assign req_wr_addr  = wr_addr_q;
  assign req_len_m1   = len_m1;
  assign req_rd_width = rdw_q;
  assign req_wr_width = wrw_q;
  assign remain_m1    = remain_q;

  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (remain_m1 == '1)); // R1
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy); // R8
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && gate_q && !dreq) |-> !bus_req); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(bus_req && bus_ack)) |=> ($stable(remain_m1) && $stable(req_rd_addr) && $stable(req_wr_addr))); // R6
  AST_FIXED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_inc_q) |=> $stable(req_rd_addr)); // R7
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && (remain_m1 == SIZE_W'(req_len_m1))) |=> (done && !busy)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(req_rd_width) && $stable(req_wr_width))); // R10
endmodule

// File: tb/dma_burst_engine_test.sv
module dma_burst_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_addr = '0, dst_addr = '0;
  logic [23:0] size_m1 = '0;
  logic [2:0]  rd_width = '0, wr_width = '0;
  logic        rd_inc = 1'b1, wr_inc = 1'b1;
  logic [7:0]  burst_m1 = '0;
  logic        dreq_en = 1'b0, dreq = 1'b0, bus_ack = 1'b0;
  logic        busy, bus_req, done;
  logic [31:0] req_rd_addr, req_wr_addr;
  logic [7:0]  req_len_m1;
  logic [2:0]  req_rd_width, req_wr_width;
  logic [23:0] remain_m1;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dma_burst_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .size_m1(size_m1), .rd_width(rd_width), .wr_width(wr_width), .rd_inc(rd_inc),
    .wr_inc(wr_inc), .burst_m1(burst_m1), .dreq_en(dreq_en), .dreq(dreq),
    .bus_ack(bus_ack), .busy(busy), .bus_req(bus_req), .req_rd_addr(req_rd_addr),
    .req_wr_addr(req_wr_addr), .req_len_m1(req_len_m1), .req_rd_width(req_rd_width),
    .req_wr_width(req_wr_width), .remain_m1(remain_m1), .done(done)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [23:0] sz;
    logic [7:0]  bm1;
    logic [7:0]  cap;
    logic [7:0]  n;
    logic [7:0]  lastm1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'h2000, 24'd99,  8'd31,  8'd31,  8'd4, 8'd3},
    '{32'h1003, 32'h2000, 24'd99,  8'd31,  8'd23,  8'd5, 8'd3},
    '{32'h1000, 32'h2000, 24'd0,   8'd15,  8'd15,  8'd1, 8'd0},
    '{32'h1000, 32'h2000, 24'd63,  8'd31,  8'd31,  8'd2, 8'd31},
    '{32'h1000, 32'h2001, 24'd9,   8'd3,   8'd3,   8'd3, 8'd1},
    '{32'h4000, 32'h8000, 24'd599, 8'd255, 8'd255, 8'd3, 8'd87}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input logic ri, input logic wi);
    int rem, nb, elen, lastlen;
    logic [31:0] er, ew;
    @(negedge clk);
    src_addr = v.src; dst_addr = v.dst; size_m1 = v.sz; burst_m1 = v.bm1;
    rd_inc = ri; wr_inc = wi; dreq_en = 1'b0; bus_ack = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && remain_m1 == v.sz, "R2 load", remain_m1, v.sz);
    rem = int'(v.sz) + 1; er = v.src; ew = v.dst; nb = 0; lastlen = 0;
    while (busy && nb < 200) begin
      elen = (rem < int'(v.cap) + 1) ? rem : int'(v.cap) + 1;
      chk(bus_req, "R8 req", bus_req, 1);
      chk(req_len_m1 == 8'(elen - 1), (rem > int'(v.cap) + 1) ? "R3/R4 len" : "R5 tail", req_len_m1, elen - 1);
      chk(req_rd_addr == er, "R7 rd addr", req_rd_addr, er);
      chk(req_wr_addr == ew, "R7 wr addr", req_wr_addr, ew);
      lastlen = elen;
      rem -= elen;
      if (ri) er += 32'(elen);
      if (wi) ew += 32'(elen);
      nb++;
      @(negedge clk);
      if (rem > 0) chk(remain_m1 == 24'(rem - 1), "R6 count", remain_m1, rem - 1);
    end
    chk(nb == int'(v.n), "R3 burst count", nb, v.n);
    chk(lastlen - 1 == int'(v.lastm1), "R5 last len", lastlen - 1, v.lastm1);
    chk(done && !busy, "R9 done", done, 1);
    chk(remain_m1 == 24'hFFFFFF, "R9 remain ones", remain_m1, 24'hFFFFFF);
    @(negedge clk);
    chk(!done, "R9 single pulse", done, 0);
    bus_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done, "R1 idle flags", {busy, bus_req, done}, 0);
    chk(remain_m1 == 24'hFFFFFF, "R1 remain ones", remain_m1, 24'hFFFFFF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b1, 1'b1);

    // fixed read address (peripheral FIFO side)
    v = VECS[0];
    run_vec(v, 1'b0, 1'b1);

    // stall, start while busy, width capture
    @(negedge clk);
    src_addr = 32'h100; dst_addr = 32'h200; size_m1 = 24'd99; burst_m1 = 8'd31;
    rd_width = 3'd2; wr_width = 3'd1; rd_inc = 1'b1; wr_inc = 1'b1; bus_ack = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rd_width = 3'd0; wr_width = 3'd3;
    repeat (3) @(negedge clk);
    chk(remain_m1 == 24'd99, "R6 stall count", remain_m1, 99);
    chk(req_rd_addr == 32'h100, "R6 stall addr", req_rd_addr, 32'h100);
    chk(req_rd_width == 3'd2 && req_wr_width == 3'd1, "R10 widths", {req_rd_width, req_wr_width}, {3'd2, 3'd1});
    src_addr = 32'h900; size_m1 = 24'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(remain_m1 == 24'd99 && req_rd_addr == 32'h100, "R2 start ignored", remain_m1, 99);
    bus_ack = 1'b1;
    for (int k = 0; k < 20 && busy; k++) @(negedge clk);
    chk(!busy && remain_m1 == 24'hFFFFFF, "R9 finished", remain_m1, 24'hFFFFFF);
    bus_ack = 1'b0;

    // peripheral request pacing
    @(negedge clk);
    src_addr = 32'h0; dst_addr = 32'h40; size_m1 = 24'd15; burst_m1 = 8'd7;
    dreq_en = 1'b1; dreq = 1'b0; bus_ack = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy && !bus_req, "R8 gated", bus_req, 0);
    chk(remain_m1 == 24'd15, "R8 no progress", remain_m1, 15);
    dreq = 1'b1;
    #0;
    chk(bus_req, "R8 released", bus_req, 1);
    @(negedge clk);
    chk(remain_m1 == 24'd7, "R8 one burst", remain_m1, 7);
    dreq = 1'b0;
    @(negedge clk);
    chk(remain_m1 == 24'd7, "R8 regated", remain_m1, 7);
    dreq = 1'b1;
    @(negedge clk);
    chk(done && !busy, "R9 paced done", done, 1);
    dreq_en = 1'b0; dreq = 1'b0; bus_ack = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule